// File: doc/BRIEF.md
# I2C Channel Bus Control and Error Register

This block is the control and status register of one I2C controller channel. It sits on a simple 32-bit register bus at byte offset 04h and keeps eight control and status bits in its low byte. These are the bus-error flag and its interrupt enable, a repeated-START request, master select, acknowledge enable, general-call acknowledge enable, the transfer interrupt enable and the transfer interrupt flag.

The block also watches the SCL and SDA lines. While a byte is being shifted, an SDA change seen while SCL is high is a START or STOP in the wrong place. Such an event is a bus error. The block then latches the error flag and drives a stop output. That output forces the channel enable held elsewhere to 0 and halts the shift engine. The shift engine itself is seen only through a few strobes:
- a byte-in-progress level,
- a byte-complete pulse,
- a repeated-START acknowledge pulse,
- the channel-enable level.

A level interrupt output combines the two flag and enable pairs.

Top module: `i2c_busctl_reg`

## Requirements
- R1: After reset, every register bit is 0, `irq` is 0, `chan_stop` is 0 and a read of the register returns 0.
- R2: A read at offset 04h returns the flags in bits 7..0 in this order: 7 bus error, 6 bus-error interrupt enable, 5 repeated-START request, 4 master select, 3 acknowledge enable, 2 general-call enable, 1 transfer interrupt enable, 0 transfer interrupt flag. Bits 31..8 read as 0. A read at any other offset returns 0.
- R3: A write changes the register only when `bus_be[0]` is 1. Other lanes and bus data bits 31..8 have no effect.
- R4: SCL and SDA pass through a two-flop synchronizer. The bus-error flag sets when the synchronized SDA changes while the synchronized SCL is high, `xfer_busy` is 1 and `chan_en` is 1. An SDA change while SCL is low, or while `xfer_busy` is 0, sets nothing.
- R5: Writing 0 to bit 7 clears the bus-error flag. Writing 1 leaves it unchanged. A new error in the same cycle wins over the clear.
- R6: While the bus-error flag is 1, `chan_stop` is 1. When the flag sets, the repeated-START request clears.
- R7: `irq` is 1 exactly when (bit 7 and bit 6) or (bit 0 and bit 1) are both 1.
- R8: Writing 1 to bit 5 sets the repeated-START request only if bit 4 is already 1. Writing 0 to bit 5 has no effect.
- R9: A `rs_ack` pulse clears the repeated-START request at the clock edge where it is sampled. That clear wins over a write in the same cycle.
- R10: While `chan_en` is 0, bits 5..0 are held at 0. Bits 7 and 6 keep their value and stay writable.
- R11: A `byte_done` pulse while `chan_en` is 1 sets bit 0. Writing 0 to bit 0 clears it and writing 1 has no effect. A pulse in the same cycle wins over the clear. Bits 4..1 take the written value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_sel | input | 1 | Register access strobe |
| bus_wr | input | 1 | 1 for write, 0 for read |
| bus_addr | input | ADDR_W | Byte offset of the access |
| bus_be | input | DATA_W/8 | Byte-lane enables |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data, combinational |
| scl_in | input | 1 | SCL line level, asynchronous |
| sda_in | input | 1 | SDA line level, asynchronous |
| xfer_busy | input | 1 | Engine is shifting a byte |
| byte_done | input | 1 | Byte-complete pulse from the engine |
| rs_ack | input | 1 | Engine has taken the repeated-START request |
| chan_en | input | 1 | Channel enable level |
| chan_stop | output | 1 | Forces the channel enable to 0 and halts the engine |
| rs_req | output | 1 | Repeated-START request to the engine |
| master_mode | output | 1 | Master select |
| ack_en | output | 1 | Acknowledge enable |
| gcall_en | output | 1 | General-call acknowledge enable |
| irq | output | 1 | Level interrupt |

## Verification
The hardest state to reach from the ports is a bus error during a live master transfer. Reaching it needs the channel enabled, master select set, a pending repeated-START request and the bus-error interrupt enable set, all before the line event occurs. After the event, the flag has to be observed across the synchronizer delay.

Directed sequences build that state one write at a time. They then flip SDA with SCL high while `xfer_busy` is 1. Contrasting flips with SCL low, and with `xfer_busy` at 0, show the qualification. Random writes, byte-lane patterns, enable toggles and engine pulses cover the ordinary control bits against a bench model of the register.

// File: rtl/i2c_busctl_reg.sv
module i2c_busctl_reg #(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32,
  parameter logic [ADDR_W-1:0] REG_OFS = 'h04
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                bus_sel,
  input  logic                bus_wr,
  input  logic [ADDR_W-1:0]   bus_addr,
  input  logic [DATA_W/8-1:0] bus_be,
  input  logic [DATA_W-1:0]   bus_wdata,
  output logic [DATA_W-1:0]   bus_rdata,
  input  logic                scl_in,
  input  logic                sda_in,
  input  logic                xfer_busy,
  input  logic                byte_done,
  input  logic                rs_ack,
  input  logic                chan_en,
  output logic                chan_stop,
  output logic                rs_req,
  output logic                master_mode,
  output logic                ack_en,
  output logic                gcall_en,
  output logic                irq
);
  localparam int PAD_W = DATA_W - 8;

  logic [1:0] scl_s, sda_s;
  logic       scl_p, sda_p;
  logic       berr, beie, scc, mss, acke, gcae, inte, intf;
  logic [7:0] ctl;
  logic       hit, wr0, misplaced;

  assign hit = bus_sel && (bus_addr == REG_OFS);
  assign wr0 = hit && bus_wr && bus_be[0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_s <= 2'b11;
      sda_s <= 2'b11;
      scl_p <= 1'b1;
      sda_p <= 1'b1;
    end else begin
      scl_s <= {scl_s[0], scl_in};
      sda_s <= {sda_s[0], sda_in};
      scl_p <= scl_s[1];
      sda_p <= sda_s[1];
    end
  end

  assign misplaced = chan_en && xfer_busy && scl_s[1] && scl_p && (sda_s[1] != sda_p);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      berr <= 1'b0;
      beie <= 1'b0;
    end else begin
      if (wr0) begin
        beie <= bus_wdata[6];
        if (!bus_wdata[7]) berr <= 1'b0;
      end
      if (misplaced) berr <= 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scc  <= 1'b0;
      mss  <= 1'b0;
      acke <= 1'b0;
      gcae <= 1'b0;
      inte <= 1'b0;
      intf <= 1'b0;
    end else if (!chan_en) begin
      scc  <= 1'b0;
      mss  <= 1'b0;
      acke <= 1'b0;
      gcae <= 1'b0;
      inte <= 1'b0;
      intf <= 1'b0;
    end else begin
      if (wr0) begin
        mss  <= bus_wdata[4];
        acke <= bus_wdata[3];
        gcae <= bus_wdata[2];
        inte <= bus_wdata[1];
        if (bus_wdata[5] && mss) scc <= 1'b1;
        if (!bus_wdata[0]) intf <= 1'b0;
      end
      if (byte_done) intf <= 1'b1;
      if (rs_ack || misplaced) scc <= 1'b0;
    end
  end

  assign ctl         = {berr, beie, scc, mss, acke, gcae, inte, intf};
  assign bus_rdata   = (hit && !bus_wr) ? {{PAD_W{1'b0}}, ctl} : '0;
  assign chan_stop   = berr;
  assign rs_req      = scc;
  assign master_mode = mss;
  assign ack_en      = acke;
  assign gcall_en    = gcae;
  assign irq         = (berr && beie) || (intf && inte);
endmodule

// File: rtl/i2c_busctl_reg_chk.sv
module i2c_busctl_reg_chk #(
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bus_sel,
  input logic              bus_wr,
  input logic              be0,
  input logic [DATA_W-1:0] bus_rdata,
  input logic              chan_en,
  input logic              rs_ack,
  input logic [7:0]        ctl,
  input logic              irq,
  input logic              chan_stop
);
  AST_RSV_ZERO:    assert property (@(posedge clk) disable iff (!rst_n) bus_rdata[DATA_W-1:8] == '0); // R2
  AST_BER_STICKY:  assert property (@(posedge clk) disable iff (!rst_n) ctl[7] && !(bus_sel && bus_wr && be0) |=> ctl[7]); // R5
  AST_STOP_ON_ERR: assert property (@(posedge clk) disable iff (!rst_n) ctl[7] |-> chan_stop); // R6
  AST_IRQ_ERR:     assert property (@(posedge clk) disable iff (!rst_n) ctl[7] && ctl[6] |-> irq); // R7
  AST_SCC_GATED:   assert property (@(posedge clk) disable iff (!rst_n) $rose(ctl[5]) |-> $past(ctl[4])); // R8
  AST_SCC_ACK:     assert property (@(posedge clk) disable iff (!rst_n) rs_ack |=> !ctl[5]); // R9
  AST_DIS_CLEAR:   assert property (@(posedge clk) disable iff (!rst_n) !chan_en |=> ctl[5:0] == 6'd0); // R10
endmodule

bind i2c_busctl_reg i2c_busctl_reg_chk #(.DATA_W(DATA_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr), .be0(bus_be[0]),
  .bus_rdata(bus_rdata), .chan_en(chan_en), .rs_ack(rs_ack), .ctl(ctl),
  .irq(irq), .chan_stop(chan_stop)
);

// File: tb/i2c_busctl_reg_tb.sv
module i2c_busctl_reg_tb_top;
  localparam int CLK_PERIOD = 10;

  logic        clk = 0, rst_n = 0;
  logic        bus_sel = 0, bus_wr = 0;
  logic [7:0]  bus_addr = 0;
  logic [3:0]  bus_be = 0;
  logic [31:0] bus_wdata = 0, bus_rdata;
  logic        scl_in = 1, sda_in = 1, xfer_busy = 0, byte_done = 0, rs_ack = 0, chan_en = 0;
  logic        chan_stop, rs_req, master_mode, ack_en, gcall_en, irq;

  int vectors = 0, errors = 0;
  logic [7:0] mdl = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  i2c_busctl_reg dut_i (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_be(bus_be), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .scl_in(scl_in),
    .sda_in(sda_in), .xfer_busy(xfer_busy), .byte_done(byte_done), .rs_ack(rs_ack),
    .chan_en(chan_en), .chan_stop(chan_stop), .rs_req(rs_req), .master_mode(master_mode),
    .ack_en(ack_en), .gcall_en(gcall_en), .irq(irq)
  );

  function automatic logic [7:0] nxt(logic [7:0] r, bit we, logic [7:0] wd, bit en, bit bd, bit ack);
    logic [7:0] n = r;
    if (we) begin
      n[6] = wd[6];
      n[7] = r[7] & wd[7];
      n[4:1] = wd[4:1];
      n[5] = r[5] | (wd[5] & r[4]);
      n[0] = r[0] & wd[0];
    end
    if (bd) n[0] = 1'b1;
    if (ack) n[5] = 1'b0;
    if (!en) n[5:0] = 6'd0;
    return n;
  endfunction

  function automatic bit irq_of(logic [7:0] r);
    return (r[7] & r[6]) | (r[0] & r[1]);
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic step(bit we, logic [3:0] be, logic [31:0] wd, bit en, bit bd, bit ack);
    @(negedge clk);
    bus_sel = we; bus_wr = we; bus_addr = 8'h04; bus_be = be; bus_wdata = wd;
    chan_en = en; byte_done = bd; rs_ack = ack;
    @(posedge clk);
    mdl = nxt(mdl, we && be[0], wd[7:0], en, bd, ack);
    @(negedge clk);
    bus_sel = 0; bus_wr = 0; byte_done = 0; rs_ack = 0;
  endtask

  task automatic rd_check(string req);
    @(negedge clk);
    bus_sel = 1; bus_wr = 0; bus_addr = 8'h04;
    #1;
    check(req, bus_rdata, {24'd0, mdl});
    check({req, " irq R7"}, {31'd0, irq}, {31'd0, irq_of(mdl)});
    check({req, " stop R6"}, {31'd0, chan_stop}, {31'd0, mdl[7]});
    bus_sel = 0;
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) step(0, 0, 0, chan_en, 0, 0);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected finish");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h1c2b));
    repeat (3) @(negedge clk);
    rst_n = 1;
    rd_check("R1 reset");
    check("R1 irq", {31'd0, irq}, 0);

    step(1, 4'hF, 32'h0000_001E, 1, 0, 0);
    @(negedge clk); bus_sel = 1; bus_addr = 8'h08; #1;
    check("R2 other offset", bus_rdata, 0);
    bus_sel = 0;
    rd_check("R2 layout");
    step(1, 4'hE, 32'hFFFF_FF00, 1, 0, 0);
    rd_check("R3 lane gating");

    step(1, 4'h1, 32'h0000_0000, 1, 0, 0);
    step(1, 4'h1, 32'h0000_0020, 1, 0, 0);
    rd_check("R8 scc ignored without mss");
    step(1, 4'h1, 32'h0000_0010, 1, 0, 0);
    step(1, 4'h1, 32'h0000_0030, 1, 0, 0);
    rd_check("R8 scc set");
    check("R8 rs_req", {31'd0, rs_req}, 1);
    step(1, 4'h1, 32'h0000_0010, 1, 0, 0);
    rd_check("R8 write 0 keeps scc");
    step(0, 0, 0, 1, 0, 1);
    rd_check("R9 ack clears scc");
    step(1, 4'h1, 32'h0000_0030, 1, 0, 1);
    rd_check("R9 ack wins over write");

    step(1, 4'h1, 32'h0000_0002, 1, 1, 0);
    rd_check("R11 byte_done sets int");
    step(1, 4'h1, 32'h0000_0002, 1, 1, 0);
    rd_check("R11 pulse wins over clear");
    step(1, 4'h1, 32'h0000_0002, 1, 0, 0);
    rd_check("R11 write 0 clears int");

    for (int i = 0; i < 400; i++) begin
      int op = $urandom_range(0, 9);
      bit en = ($urandom_range(0, 7) != 0);
      case (op)
        0, 1, 2, 3, 4: step(1, 4'($urandom), $urandom, en, 0, 0);
        5, 6: step(0, 0, 0, en, 1, 0);
        7:    step(0, 0, 0, en, 0, 1);
        default: step(1, 4'($urandom), $urandom, en, $urandom_range(0, 1), 0);
      endcase
      rd_check(en ? "R3 R11 random" : "R10 random disabled");
    end

    step(1, 4'h1, 32'h0000_0050, 1, 0, 0);
    step(1, 4'h1, 32'h0000_0070, 1, 0, 0);
    @(negedge clk); xfer_busy = 1; scl_in = 0; sda_in = 0;
    idle(5);
    rd_check("R4 no error with scl low");
    @(negedge clk); scl_in = 1; xfer_busy = 0;
    idle(4);
    @(negedge clk); sda_in = 1;
    idle(5);
    rd_check("R4 no error when idle");
    @(negedge clk); xfer_busy = 1; sda_in = 0;
    idle(5);
    mdl[7] = 1; mdl[5] = 0;
    rd_check("R4 R6 error detected");
    check("R6 rs_req cleared", {31'd0, rs_req}, 0);
    check("R7 error irq", {31'd0, irq}, 1);
    @(negedge clk); xfer_busy = 0; sda_in = 1;
    idle(4);
    step(1, 4'h1, 32'h0000_00D0, 1, 0, 0);
    rd_check("R5 write 1 keeps ber");
    step(0, 0, 0, 0, 0, 0);
    rd_check("R10 disable keeps ber beie");
    step(1, 4'h1, 32'h0000_0000, 0, 0, 0);
    rd_check("R5 write 0 clears ber");
    step(1, 4'h1, 32'h0000_0040, 0, 0, 0);
    rd_check("R10 beie writable while disabled");

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule